// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control engine of a single DMA channel. It keeps a peripheral-side address, a memory-side address, a remaining-item count and a configuration word. On each accepted item it updates both addresses and the count. From the count it raises half-way and completion events. Three transfer error inputs feed the same flag bank. Every flag has its own enable, and the enabled flags are ORed into one interrupt line. The bus protocol, the data FIFO and arbitration between channels are outside the block. The block presents one item at a time on `xfer_req`. The bus side answers with `xfer_ack` once that item has moved.

Four states drive the sequencing. OFF is the disabled state. ARMED means the channel is enabled with items left and is waiting for a trigger. MOVE means an item is being offered on `xfer_req`. HALT means the channel is enabled but the count is zero in normal mode. The transitions are:
- OFF goes to ARMED, or to HALT if the count is zero, on the cycle after the enable bit is stored.
- ARMED goes to MOVE on a trigger.
- MOVE goes back to ARMED on an acknowledge. It goes to HALT instead when the last item is acknowledged in normal mode.
- Any state goes to OFF on the cycle after the enable bit is cleared.

In peripheral-paced operation the trigger is the `periph_req` level. In memory-to-memory operation a single `sw_trig` pulse starts a run, and the items then follow back to back.

Configuration word `cfg_wdata` bit fields:
- bit 0: enable
- bit 1: memory-to-peripheral direction
- bit 2: circular mode
- bit 3: peripheral address increment
- bit 4: memory address increment
- bits 6:5: item size
- bit 7: memory-to-memory
- bits 12:8: interrupt enables, one per flag, in flag order

Flag order in `evt_flags`, `flag_clr` and the enables:
- bit 0: half-way
- bit 1: complete
- bit 2: transfer error
- bit 3: FIFO error
- bit 4: direct-mode error

Top module: `dma_xfer_seq`

## Requirements
- R1: A count write holds 1 to 65535 items. `items_left` drops by one on every accepted item, that is, a cycle with `xfer_req` and `xfer_ack` both high.
- R2: The address step is set by the size code: 0 gives 1 byte, 1 gives 2 bytes, 2 or 3 gives 4 bytes. A pointer advances after each accepted item only if its increment bit is set. Otherwise it stays fixed. With the direction bit clear, or in memory-to-memory mode, `src_addr` is the peripheral pointer and `dst_addr` is the memory pointer. With the direction bit set and memory-to-memory mode off, the two are swapped.
- R3: In normal mode, once `items_left` reaches 0, `xfer_req` stays low for as long as the channel stays enabled.
- R4: Count and address writes made while the channel is enabled are ignored. Enabling the channel reloads both pointers from their last written values. Enabling with a zero count leads to HALT, so a restart needs a count rewrite while the channel is disabled.
- R5: In circular mode, the acknowledge that would bring the count to 0 instead reloads the count and both pointers to their written values, and the channel keeps running.
- R6: The half-way flag (bit 0) is set by an accepted item that leaves a count equal to the written count divided by two, rounded down. The complete flag (bit 1) is set by the acknowledge of the last item. With a count of 1, both flags are set in the same cycle.
- R7: A pulse on `err_evt[0]`, `err_evt[1]` or `err_evt[2]` sets flag bit 2, 3 or 4 respectively. This happens in any state.
- R8: `irq` is high exactly when some flag is set and its enable bit is also set.
- R9: A 1 in `flag_clr` clears the matching flag on the next edge. If a clear and a set of the same flag fall in one cycle, the flag ends set.
- R10: In memory-to-memory mode, `periph_req` is ignored. One `sw_trig` pulse moves items back to back until the count runs out.
- R11: After reset, `xfer_req`, `items_left`, `evt_flags` and `irq` are all zero. A trigger seen in ARMED raises `xfer_req` on the next cycle, and an acknowledge returns the block to ARMED.
- R12: Clearing the enable bit drops `xfer_req` from the next cycle onward. Acknowledges that arrive after that change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 13 | Configuration word |
| cnt_we | input | 1 | Item count write strobe (only acts while disabled) |
| cnt_wdata | input | CW | Item count |
| paddr_we | input | 1 | Peripheral address write strobe (only acts while disabled) |
| maddr_we | input | 1 | Memory address write strobe (only acts while disabled) |
| addr_wdata | input | AW | Address write data |
| flag_clr | input | 5 | Write-one-to-clear for the flags |
| err_evt | input | 3 | Transfer, FIFO and direct-mode error pulses |
| periph_req | input | 1 | Peripheral request level |
| sw_trig | input | 1 | Software start for memory-to-memory runs |
| xfer_ack | input | 1 | The offered item has been moved |
| xfer_req | output | 1 | An item is offered |
| src_addr | output | AW | Source address of the item |
| dst_addr | output | AW | Destination address of the item |
| xfer_size | output | 2 | Item size code |
| items_left | output | CW | Remaining item count |
| evt_flags | output | 5 | Event flags |
| irq | output | 1 | Combined interrupt |

## Verification
Two kinds of event can fall in the same cycle here. A flag can be set and cleared in one cycle. Separately, a one-item run sets the half-way and complete flags from a single acknowledge. The bench holds `flag_clr` on the half-way and complete bits right through the acknowledge of a one-item run, then releases it. It then requires both flags to read as set, which covers both coincidences at once. Circular wrap against count decrement, and disable against an acknowledge in flight, are judged cycle by cycle against the behavioural reference model.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int FLAG_N = 5;
    localparam int F_HT   = 0;
    localparam int F_TC   = 1;
    localparam int F_TE   = 2;
    localparam int F_FE   = 3;
    localparam int F_DE   = 4;
    localparam int CFG_W  = 8 + FLAG_N;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_MOVE  = 2'd2,
        ST_HALT  = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [FLAG_N-1:0] ie;
        logic              m2m;
        logic [1:0]        size;
        logic              minc;
        logic              pinc;
        logic              circ;
        logic              m2p;
        logic              en;
    } seq_cfg_t;

    function automatic logic [2:0] step_bytes(input logic [1:0] sz);
        logic [2:0] s;
        unique case (sz)
            2'd0:    s = 3'd1;
            2'd1:    s = 3'd2;
            default: s = 3'd4;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] wdata,
    input  logic          load,
    input  logic          wrap,
    input  logic          adv,
    input  logic          inc_en,
    input  logic [2:0]    step,
    output logic [AW-1:0] cur
);

    logic [AW-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cur    <= '0;
        end else if (wr) begin
            base_q <= wdata;
            cur    <= wdata;
        end else if (load || wrap) begin
            cur    <= base_q;
        end else if (adv && inc_en) begin
            cur    <= cur + AW'(step);
        end
    end

endmodule

// File: rtl/dma_item_cnt.sv
module dma_item_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          take,
    input  logic          circ,
    output logic [CW-1:0] count,
    output logic [CW-1:0] reload,
    output logic          last,
    output logic          half_hit
);

    logic [CW-1:0] count_dec;

    assign count_dec = count - CW'(1);
    assign last      = (count == CW'(1));
    assign half_hit  = take && (count_dec == (reload >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            reload <= '0;
        end else if (wr) begin
            count  <= wdata;
            reload <= wdata;
        end else if (take) begin
            if (last) begin
                count <= circ ? reload : '0;
            end else begin
                count <= count_dec;
            end
        end
    end

endmodule

// File: rtl/dma_evt_flags.sv
module dma_evt_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flags,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else begin
                flags[i] <= set[i] | (flags[i] & ~clr[i]);
            end
        end
    end

    assign irq = |(flags & ie);

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              cnt_we,
    input  logic [CW-1:0]     cnt_wdata,
    input  logic              paddr_we,
    input  logic              maddr_we,
    input  logic [AW-1:0]     addr_wdata,
    input  logic [FLAG_N-1:0] flag_clr,
    input  logic [2:0]        err_evt,
    input  logic              periph_req,
    input  logic              sw_trig,
    input  logic              xfer_ack,
    output logic              xfer_req,
    output logic [AW-1:0]     src_addr,
    output logic [AW-1:0]     dst_addr,
    output logic [1:0]        xfer_size,
    output logic [CW-1:0]     items_left,
    output logic [FLAG_N-1:0] evt_flags,
    output logic              irq
);

    seq_cfg_t          cfg_q;
    seq_cfg_t          cfg_in;
    seq_state_t        state_q;
    seq_state_t        state_d;
    logic              run_q;
    logic              en_q;
    logic              en_rise;
    logic              trig;
    logic              take;
    logic              last;
    logic              half_hit;
    logic              wrap;
    logic              finish;
    logic              swap_dir;
    logic [2:0]        step;
    logic [AW-1:0]     paddr_cur;
    logic [AW-1:0]     maddr_cur;
    logic [CW-1:0]     cnt_reload;
    logic [FLAG_N-1:0] flag_set;

    assign cfg_in   = seq_cfg_t'(cfg_wdata);
    assign en_q     = cfg_q.en;
    assign en_rise  = cfg_we && cfg_in.en && !en_q;
    assign take     = xfer_req && xfer_ack;
    assign wrap     = take && last && cfg_q.circ;
    assign finish   = take && last && !cfg_q.circ;
    assign step     = step_bytes(cfg_q.size);
    assign trig     = cfg_q.m2m ? (run_q || sw_trig) : periph_req;
    assign swap_dir = cfg_q.m2p && !cfg_q.m2m;

    // configuration word and memory-to-memory run latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            run_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                cfg_q <= cfg_in;
            end
            if (!en_q || finish) begin
                run_q <= 1'b0;
            end else if (cfg_q.m2m && sw_trig) begin
                run_q <= 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_q) begin
                    state_d = (items_left != '0) ? ST_ARMED : ST_HALT;
                end
            end
            ST_ARMED: begin
                if (!en_q) begin
                    state_d = ST_OFF;
                end else if (trig) begin
                    state_d = ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (!en_q) begin
                    state_d = ST_OFF;
                end else if (xfer_ack) begin
                    state_d = finish ? ST_HALT : ST_ARMED;
                end
            end
            ST_HALT: begin
                if (!en_q) begin
                    state_d = ST_OFF;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        xfer_req  = (state_q == ST_MOVE) && en_q;
        src_addr  = swap_dir ? maddr_cur : paddr_cur;
        dst_addr  = swap_dir ? paddr_cur : maddr_cur;
        xfer_size = cfg_q.size;
    end

    dma_addr_ptr #(.AW(AW)) u_pptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (paddr_we && !en_q),
        .wdata  (addr_wdata),
        .load   (en_rise),
        .wrap   (wrap),
        .adv    (take),
        .inc_en (cfg_q.pinc),
        .step   (step),
        .cur    (paddr_cur)
    );

    dma_addr_ptr #(.AW(AW)) u_mptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (maddr_we && !en_q),
        .wdata  (addr_wdata),
        .load   (en_rise),
        .wrap   (wrap),
        .adv    (take),
        .inc_en (cfg_q.minc),
        .step   (step),
        .cur    (maddr_cur)
    );

    dma_item_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cnt_we && !en_q),
        .wdata    (cnt_wdata),
        .take     (take),
        .circ     (cfg_q.circ),
        .count    (items_left),
        .reload   (cnt_reload),
        .last     (last),
        .half_hit (half_hit)
    );

    always_comb begin
        flag_set       = '0;
        flag_set[F_HT] = half_hit;
        flag_set[F_TC] = take && last;
        flag_set[F_TE] = err_evt[0];
        flag_set[F_FE] = err_evt[1];
        flag_set[F_DE] = err_evt[2];
    end

    dma_evt_flags #(.N(FLAG_N)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .ie    (cfg_q.ie),
        .flags (evt_flags),
        .irq   (irq)
    );

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_q,
    input logic          circ,
    input logic          pinc,
    input logic          xfer_req,
    input logic          xfer_ack,
    input logic [CW-1:0] items_left,
    input logic [CW-1:0] cnt_reload,
    input logic [AW-1:0] paddr_cur,
    input logic [4:0]    evt_flags,
    input logic          irq
);

    assert_req_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (items_left != '0));

    assert_halt_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && items_left == CW'(1) && !circ)
        |=> (items_left == '0 && !xfer_req));

    assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !(xfer_req && xfer_ack)) |=> $stable(items_left));

    assert_circ_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && items_left == CW'(1) && circ)
        |=> (items_left == $past(cnt_reload)));

    assert_done_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && items_left == CW'(1)) |=> evt_flags[1]);

    assert_paddr_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && !pinc) |=> $stable(paddr_cur));

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flags == '0) |-> !irq);

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (en_q),
    .circ       (cfg_q.circ),
    .pinc       (cfg_q.pinc),
    .xfer_req   (xfer_req),
    .xfer_ack   (xfer_ack),
    .items_left (items_left),
    .cnt_reload (cnt_reload),
    .paddr_cur  (paddr_cur),
    .evt_flags  (evt_flags),
    .irq        (irq)
);

// File: tb/test_dma_xfer_seq.sv
`timescale 1ns/1ps
module test_dma_xfer_seq;

    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [12:0]   cfg_wdata = '0;
    logic          cnt_we = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic          paddr_we = 1'b0;
    logic          maddr_we = 1'b0;
    logic [AW-1:0] addr_wdata = '0;
    logic [4:0]    flag_clr = '0;
    logic [2:0]    err_evt = '0;
    logic          periph_req = 1'b0;
    logic          sw_trig = 1'b0;
    logic          xfer_ack = 1'b0;
    logic          xfer_req;
    logic [AW-1:0] src_addr;
    logic [AW-1:0] dst_addr;
    logic [1:0]    xfer_size;
    logic [CW-1:0] items_left;
    logic [4:0]    evt_flags;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_xfer_seq #(.AW(AW), .CW(CW)) i_dma_xfer_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .paddr_we(paddr_we),
        .maddr_we(maddr_we), .addr_wdata(addr_wdata), .flag_clr(flag_clr),
        .err_evt(err_evt), .periph_req(periph_req), .sw_trig(sw_trig),
        .xfer_ack(xfer_ack), .xfer_req(xfer_req), .src_addr(src_addr),
        .dst_addr(dst_addr), .xfer_size(xfer_size), .items_left(items_left),
        .evt_flags(evt_flags), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_cnt, m_rld, m_phase;
    logic [31:0] m_pb, m_pc, m_mb, m_mc;
    logic [12:0] m_cfg;
    logic [4:0]  m_flags;
    bit          m_run;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_rld = 0; m_phase = 0; m_pb = 0; m_pc = 0;
            m_mb = 0; m_mc = 0; m_cfg = 0; m_flags = 0; m_run = 0;
        end else begin
            bit en, circ, acc, trg, endit;
            int step, nph;
            logic [4:0] setv;
            en    = m_cfg[0];
            circ  = m_cfg[2];
            step  = (m_cfg[6:5] == 0) ? 1 : (m_cfg[6:5] == 1) ? 2 : 4;
            acc   = (m_phase == 2) && en && xfer_ack;
            trg   = m_cfg[7] ? (m_run || sw_trig) : periph_req;
            endit = acc && (m_cnt == 1);
            case (m_phase)
                0: nph = en ? ((m_cnt != 0) ? 1 : 3) : 0;
                1: nph = !en ? 0 : (trg ? 2 : 1);
                2: nph = !en ? 0 : (acc ? ((endit && !circ) ? 3 : 1) : 2);
                default: nph = !en ? 0 : 3;
            endcase
            setv = {err_evt, endit, acc && ((m_cnt - 1) == (m_rld / 2))};
            m_flags = setv | (m_flags & ~flag_clr);
            if (paddr_we && !en) begin m_pb = addr_wdata; m_pc = addr_wdata; end
            else if ((cfg_we && cfg_wdata[0] && !en) || (endit && circ)) m_pc = m_pb;
            else if (acc && m_cfg[3]) m_pc = m_pc + step;
            if (maddr_we && !en) begin m_mb = addr_wdata; m_mc = addr_wdata; end
            else if ((cfg_we && cfg_wdata[0] && !en) || (endit && circ)) m_mc = m_mb;
            else if (acc && m_cfg[4]) m_mc = m_mc + step;
            if (cnt_we && !en) begin m_cnt = cnt_wdata; m_rld = cnt_wdata; end
            else if (acc) m_cnt = (m_cnt == 1) ? (circ ? m_rld : 0) : m_cnt - 1;
            if (!en || (endit && !circ)) m_run = 0;
            else if (m_cfg[7] && sw_trig) m_run = 1;
            if (cfg_we) m_cfg = cfg_wdata;
            m_phase = nph;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] es, ed;
            bit sw;
            sw = m_cfg[1] && !m_cfg[7];
            es = sw ? m_mc : m_pc;
            ed = sw ? m_pc : m_mc;
            check(xfer_req == ((m_phase == 2) && m_cfg[0]), "R11 xfer_req", xfer_req, (m_phase == 2) && m_cfg[0]);
            check(items_left == m_cnt[15:0], "R1 items_left", items_left, m_cnt);
            check(src_addr == es, "R2 src_addr", src_addr, es);
            check(dst_addr == ed, "R2 dst_addr", dst_addr, ed);
            check(xfer_size == m_cfg[6:5], "R2 xfer_size", xfer_size, m_cfg[6:5]);
            check(evt_flags == m_flags, "R6 evt_flags", evt_flags, m_flags);
            check(irq == |(m_flags & m_cfg[12:8]), "R8 irq", irq, |(m_flags & m_cfg[12:8]));
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [12:0] mk(bit en, bit m2p, bit circ, bit pinc, bit minc,
                                       logic [1:0] sz, bit m2m, logic [4:0] ie);
        return {ie, m2m, sz, minc, pinc, circ, m2p, en};
    endfunction

    task automatic wr_cfg(input logic [12:0] w);
        cfg_we = 1; cfg_wdata = w; @(negedge clk); cfg_we = 0;
    endtask
    task automatic wr_cnt(input int n);
        cnt_we = 1; cnt_wdata = n[15:0]; @(negedge clk); cnt_we = 0;
    endtask
    task automatic wr_pa(input logic [31:0] a);
        paddr_we = 1; addr_wdata = a; @(negedge clk); paddr_we = 0;
    endtask
    task automatic wr_ma(input logic [31:0] a);
        maddr_we = 1; addr_wdata = a; @(negedge clk); maddr_we = 0;
    endtask
    task automatic clr_all();
        flag_clr = 5'h1f; @(negedge clk); flag_clr = 0;
    endtask
    task automatic wait_items(input int k);
        for (int i = 0; i < k; i++) begin
            while (!xfer_req) @(negedge clk);
            @(negedge clk);
        end
    endtask
    task automatic watch_no_req(input int n, input string req);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (xfer_req) seen = 1;
        end
        check(!seen, req, seen, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state (R11)
        check(xfer_req == 0, "R11 reset xfer_req", xfer_req, 0);
        check(items_left == 0, "R11 reset items_left", items_left, 0);
        check(evt_flags == 0 && irq == 0, "R11 reset flags", {evt_flags, irq}, 0);

        // normal memory-to-peripheral, fixed peripheral pointer, bytes
        wr_pa(32'h4000_0010);
        wr_ma(32'h2000_0000);
        wr_cnt(4);
        periph_req = 1; xfer_ack = 1;
        wr_cfg(mk(1, 1, 0, 0, 1, 2'd0, 0, 5'b00011));
        repeat (20) @(negedge clk);
        check(items_left == 0, "R1 count ran down", items_left, 0);
        check(src_addr == 32'h2000_0004, "R2 memory source stepped by 1", src_addr, 32'h2000_0004);
        check(dst_addr == 32'h4000_0010, "R2 fixed peripheral dest", dst_addr, 32'h4000_0010);
        check(evt_flags == 5'b00011, "R6 half and complete", evt_flags, 5'b00011);
        check(irq == 1, "R8 irq from enabled flags", irq, 1);
        watch_no_req(8, "R3 no request at zero");

        // writes while enabled are ignored, restart rules
        wr_cnt(9);
        wr_ma(32'h3000_0000);
        @(negedge clk);
        check(items_left == 0, "R4 count write ignored", items_left, 0);
        check(src_addr == 32'h2000_0004, "R4 address write ignored", src_addr, 32'h2000_0004);
        wr_cfg(mk(0, 1, 0, 0, 1, 2'd0, 0, 5'b00011));
        clr_all();
        check(evt_flags == 0 && irq == 0, "R9 clear by write-one", evt_flags, 0);
        wr_cfg(mk(1, 1, 0, 0, 1, 2'd0, 0, 5'b00011));
        watch_no_req(10, "R4 no restart without rewrite");
        check(src_addr == 32'h2000_0000, "R4 pointer reload on enable", src_addr, 32'h2000_0000);
        wr_cfg(mk(0, 1, 0, 0, 1, 2'd0, 0, 5'b00011));
        wr_cnt(2);
        wr_cfg(mk(1, 1, 0, 0, 1, 2'd0, 0, 5'b00011));
        repeat (12) @(negedge clk);
        check(items_left == 0 && src_addr == 32'h2000_0002, "R4 restart after rewrite", src_addr, 32'h2000_0002);

        // circular, words, both pointers incrementing
        wr_cfg(mk(0, 0, 1, 1, 1, 2'd2, 0, 5'b00010));
        clr_all();
        wr_pa(32'h0000_1000);
        wr_ma(32'h0000_8000);
        wr_cnt(3);
        wr_cfg(mk(1, 0, 1, 1, 1, 2'd2, 0, 5'b00010));
        wait_items(4);
        periph_req = 0;
        check(items_left == 2, "R5 count reloaded", items_left, 2);
        check(src_addr == 32'h0000_1004, "R5 source pointer wrapped", src_addr, 32'h0000_1004);
        check(dst_addr == 32'h0000_8004, "R5 dest pointer wrapped", dst_addr, 32'h0000_8004);
        check(evt_flags == 5'b00011 && irq, "R6 flags in circular lap", evt_flags, 5'b00011);
        watch_no_req(5, "R11 no trigger holds ARMED");

        // memory-to-memory, software start
        wr_cfg(mk(0, 1, 0, 1, 1, 2'd1, 1, 5'b00000));
        clr_all();
        wr_pa(32'h0000_0100);
        wr_ma(32'h0000_0200);
        wr_cnt(3);
        periph_req = 1;
        wr_cfg(mk(1, 1, 0, 1, 1, 2'd1, 1, 5'b00000));
        watch_no_req(6, "R10 peripheral request ignored");
        periph_req = 0;
        sw_trig = 1; @(negedge clk); sw_trig = 0;
        repeat (12) @(negedge clk);
        check(items_left == 0, "R10 run completed", items_left, 0);
        check(src_addr == 32'h0000_0106, "R10 source from peripheral pointer", src_addr, 32'h0000_0106);
        check(dst_addr == 32'h0000_0206, "R10 dest memory pointer", dst_addr, 32'h0000_0206);

        // error flags and set-wins-over-clear
        wr_cfg(mk(0, 0, 0, 0, 0, 2'd0, 0, 5'b10000));
        clr_all();
        err_evt = 3'b101; @(negedge clk); err_evt = 0;
        check(evt_flags == 5'b10100, "R7 error flags set", evt_flags, 5'b10100);
        check(irq == 1, "R8 direct-mode error enabled", irq, 1);
        wr_cnt(1);
        flag_clr = 5'b00011;
        periph_req = 1;
        wr_cfg(mk(1, 0, 0, 0, 0, 2'd0, 0, 5'b10000));
        while (!xfer_req) @(negedge clk);
        @(negedge clk);
        flag_clr = 0;
        periph_req = 0;
        check(evt_flags == 5'b10111, "R9 set wins over clear (R6 one-item run)", evt_flags, 5'b10111);

        // disable while an item is offered
        wr_cfg(mk(0, 0, 0, 0, 0, 2'd0, 0, 5'b00000));
        wr_cnt(5);
        xfer_ack = 0;
        periph_req = 1;
        wr_cfg(mk(1, 0, 0, 0, 0, 2'd0, 0, 5'b00000));
        while (!xfer_req) @(negedge clk);
        wr_cfg(mk(0, 0, 0, 0, 0, 2'd0, 0, 5'b00000));
        check(xfer_req == 0, "R12 request dropped", xfer_req, 0);
        xfer_ack = 1;
        repeat (4) @(negedge clk);
        check(items_left == 5, "R12 late acknowledge ignored", items_left, 5);
        periph_req = 0; xfer_ack = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule